// File: doc/BRIEF.md
# Scanned Hex Adder Display Driver

This block takes two 4-bit hexadecimal operands from an 8-bit switch bus and shows them, with their sum, on a four-digit 7-segment display that is driven one digit at a time. One digit carries operand A, one carries operand B, and the remaining two carry the sum. The sum needs two digits because it can reach 0x1E.

A free-running scan counter steps through the four digit positions. On every step the block enables exactly one digit and drives the segment pattern for the nibble that belongs to that digit. The digit enables and the segment lines are active low. A parameter sets how many clocks each digit stays lit, so a slow board clock can still give a flicker-free display.

The switches are plain level inputs. They are not a data stream, so there is no valid/ready handshake and no back-pressure. The segment lines follow the switches in the same cycle.

Top module: `hexsum_scan_display`

## Requirements
- R1: Operand A is `sw[3:0]`. It is shown while scan position 3 is active, that is while `dig_n[3]` is low.
- R2: Operand B is `sw[7:4]`. It is shown while scan position 2 is active, that is while `dig_n[2]` is low.
- R3: The scan position steps 0, 1, 2, 3 and then wraps back to 0, forever. In scan position s, only `dig_n[s]` is low and the other three digit lines are high.
- R4: The sum A+B is formed as an 8-bit value. Its low nibble is shown at scan position 0 and its high nibble at scan position 1. For F+F, position 0 shows E and position 1 shows 1.
- R5: The segment code is positive-polarity before inversion, with bit 0 as segment a up to bit 6 as segment g. The codes are:
  - 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07
  - 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71
- R6: Both output buses are active low. `seg_n[6:0]` is the bitwise inverse of the R5 code, and `dig_n` is the inverse of the one-hot digit enable.
- R7: `seg_n[7]` is the decimal-point segment. It is always 1 (unlit).
- R8: Each scan position lasts exactly PRESCALE clock cycles before the scan advances.
- R9: The synchronous reset `rst` clears the prescaler and the scan position. The first cycle after reset shows scan position 0, and that position then lasts a full PRESCALE cycles.
- R10: The segment bus and the digit bus change in the same cycle. The segment pattern reflects the current switch value in that same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | 8 | Switch bus: B in [7:4], A in [3:0] |
| seg_n | output | 8 | Active-low segments: [7] decimal point, [6:0] segments g..a |
| dig_n | output | 4 | Active-low digit enables, one low at a time |

## Verification
The bench sweeps all 256 pairs of A and B. This exposes any swap between the operand digits and the sum digits, any wrong carry in the high sum nibble, and any wrong entry in the segment table. The switches change at points that are not aligned to the scan. This separates a combinational segment path from a registered one. The bench uses a prescale value above one, which separates a wrong step length from a wrong step order, and applies a reset in the middle of a scan to show that the prescaler restarts cleanly.

// File: rtl/hexsum_pkg.sv
package hexsum_pkg;
  localparam int NIB_W   = 4;
  localparam int DIGITS  = 4;
  localparam int SEG_W   = 7;
  localparam int SCAN_W  = $clog2(DIGITS);
  localparam int WORD_W  = NIB_W * DIGITS;
  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [SCAN_W-1:0] scan_t;
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int PRESCALE = 1,
  parameter int DIGITS   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic [$clog2(DIGITS)-1:0] scan
);
  localparam int SW = $clog2(DIGITS);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [SW-1:0] SCAN_LAST = SW'(DIGITS - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      scan <= '0;
    end else if (pre == PRE_LAST) begin
      pre  <= '0;
      scan <= (scan == SCAN_LAST) ? '0 : scan + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/digit_decoder.sv
module digit_decoder #(
  parameter int DIGITS = 4
) (
  input  logic [$clog2(DIGITS)-1:0] sel,
  output logic [DIGITS-1:0]         onehot
);
  localparam int SW = $clog2(DIGITS);
  for (genvar i = 0; i < DIGITS; i++) begin : g_dec
    assign onehot[i] = (sel == SW'(i));
  end
endmodule

// File: rtl/nibble_select.sv
module nibble_select #(
  parameter int DIGITS = 4,
  parameter int NIB_W  = 4
) (
  input  logic [DIGITS*NIB_W-1:0]   word,
  input  logic [$clog2(DIGITS)-1:0] sel,
  output logic [NIB_W-1:0]          nib
);
  logic [NIB_W-1:0] lane [DIGITS];
  for (genvar i = 0; i < DIGITS; i++) begin : g_lane
    assign lane[i] = word[i*NIB_W +: NIB_W];
  end
  assign nib = lane[sel];
endmodule

// File: rtl/hex_to_seg.sv
module hex_to_seg
  import hexsum_pkg::*;
(
  input  nib_t hex,
  output seg_t seg
);
  always_comb begin
    unique case (hex)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end
endmodule

// File: rtl/hexsum_scan_display.sv
module hexsum_scan_display
  import hexsum_pkg::*;
#(
  parameter int PRESCALE = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [7:0]   sw,
  output logic [7:0]   seg_n,
  output logic [3:0]   dig_n
);
  localparam int SUM_W = 2 * NIB_W;

  nib_t              op_a, op_b, shown;
  logic [SUM_W-1:0]  sum;
  logic [WORD_W-1:0] word;
  scan_t             scan;
  logic [DIGITS-1:0] dig_on;
  seg_t              seg_on;

  assign op_a = sw[NIB_W-1:0];
  assign op_b = sw[2*NIB_W-1:NIB_W];
  assign sum  = SUM_W'(op_a) + SUM_W'(op_b);
  assign word = {op_a, op_b, sum};

  scan_timer #(.PRESCALE(PRESCALE), .DIGITS(DIGITS)) u_timer (
    .clk(clk), .rst(rst), .scan(scan)
  );

  digit_decoder #(.DIGITS(DIGITS)) u_dec (
    .sel(scan), .onehot(dig_on)
  );

  nibble_select #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_sel (
    .word(word), .sel(scan), .nib(shown)
  );

  hex_to_seg u_seg (.hex(shown), .seg(seg_on));

  assign seg_n = {1'b1, ~seg_on};
  assign dig_n = ~dig_on;
endmodule

// File: rtl/hexsum_scan_display_chk.sv
module hexsum_scan_display_chk #(
  parameter int PRESCALE = 1
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] sw,
  input logic [7:0] seg_n,
  input logic [3:0] dig_n
);
  logic [3:0] prev_dig;
  int         hold_cnt;

  always_ff @(posedge clk) begin
    prev_dig <= dig_n;
    if (rst) hold_cnt <= 0;
    else if (dig_n != prev_dig) hold_cnt <= 0;
    else hold_cnt <= hold_cnt + 1;
  end

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
    $countones(~dig_n) == 1); // R3
  AST_SCAN_ROTATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dig_n) |-> (~dig_n) == {~$past(dig_n[2:0]), ~$past(dig_n[3])}); // R3
  AST_DP_DARK: assert property (@(posedge clk) disable iff (rst)
    seg_n[7] == 1'b1); // R7
  AST_RESET_POS0: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dig_n == 4'b1110); // R9
  AST_STEP_PERIOD: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= PRESCALE); // R8
  AST_SEG_STEADY: assert property (@(posedge clk) disable iff (rst)
    $stable(dig_n) && $stable(sw) |-> $stable(seg_n)); // R10
endmodule

bind hexsum_scan_display hexsum_scan_display_chk #(.PRESCALE(PRESCALE)) u_chk (.*);

// File: tb/hexsum_scan_display_tb.sv
`timescale 1ns/1ps
module hexsum_scan_display_tb;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sw  = 8'h00;
  logic [7:0] seg_n;
  logic [3:0] dig_n;

  int errors = 0;
  int checks = 0;
  int m_scan = 0;
  int m_pre  = 0;
  bit started = 0;
  bit done = 0;

  logic [6:0] code [16];

  hexsum_scan_display #(.PRESCALE(P)) u_dut (
    .clk(clk), .rst(rst), .sw(sw), .seg_n(seg_n), .dig_n(dig_n)
  );

  always #5 clk = ~clk;

  initial begin
    code[0]=7'h3F; code[1]=7'h06; code[2]=7'h5B; code[3]=7'h4F;
    code[4]=7'h66; code[5]=7'h6D; code[6]=7'h7D; code[7]=7'h07;
    code[8]=7'h7F; code[9]=7'h6F; code[10]=7'h77; code[11]=7'h7C;
    code[12]=7'h39; code[13]=7'h5E; code[14]=7'h79; code[15]=7'h71;
  end

  // behavioural reference: R8 step length, R3 wrap, R9 reset
  always @(posedge clk) begin
    if (rst) begin
      m_scan = 0; m_pre = 0; started = 1;
    end else if (m_pre == P - 1) begin
      m_pre = 0; m_scan = (m_scan + 1) % 4;
    end else begin
      m_pre = m_pre + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      int a, b, s, nib;
      string tag;
      a = sw[3:0]; b = sw[7:4]; s = a + b;
      case (m_scan)
        0: begin nib = s % 16; tag = "R4 low"; end
        1: begin nib = s / 16; tag = "R4 high"; end
        2: begin nib = b;      tag = "R2"; end
        default: begin nib = a; tag = "R1"; end
      endcase
      check(dig_n == ~(4'b0001 << m_scan), "R3/R8 digit R6", int'(dig_n), int'(~(4'b0001 << m_scan)));
      check(seg_n[6:0] == ~code[nib], {tag, " R5 R6 R10 seg"}, int'(seg_n[6:0]), int'(~code[nib]));
      check(seg_n[7] == 1'b1, "R7 dp", int'(seg_n[7]), 1);
    end
  end

  task automatic do_reset(input int n);
    @(posedge clk); #1 rst = 1'b1;
    repeat (n) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(dig_n == 4'b1110, "R9 reset pos0", int'(dig_n), 4'hE);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(dig_n == 4'b1110, "R9 initial", int'(dig_n), 4'hE);
    // exhaustive sweep, one full scan each
    for (int v = 0; v < 256; v++) begin
      sw = v[7:0];
      repeat (4 * P) @(posedge clk);
      #1;
    end
    // switches changed mid-step, not aligned to scan (R10)
    for (int k = 0; k < 40; k++) begin
      sw = 8'((k * 37 + 11) & 8'hFF);
      repeat (k % 5 + 1) @(posedge clk);
      #3;
    end
    // reset in the middle of a step (R9)
    sw = 8'hFF;
    repeat (4) @(posedge clk);
    do_reset(2);
    repeat (8 * P) @(posedge clk);
    do_reset(3);
    repeat (8 * P) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule